// File: doc/BRIEF.md
# Banked Protection-Region Configuration Register Bank

This block is the register file behind a small memory protection unit. For each region it stores an upper-limit field, a 3-bit attribute index and an enable bit. It also stores a region-select register and two 32-bit attribute words, each holding four 8-bit memory-attribute codes. There are two complete copies of this state, one for the secure security state and one for the non-secure state. A single-cycle request port carries address, write data, write flag, byte strobes, privilege and security state. The block returns registered read data and a bus-fault flag one cycle later.

A limit register can be reached in two ways. The main limit address uses the select register as it stands. Three alias addresses (n = 1, 2, 3) replace the two low bits of the select value with n, so software can program four neighbouring regions without rewriting the select register. Secure software can also reach the non-secure copy through a second window placed 0x2_0000 above the main one. Non-secure software is refused that window.

For every region of both copies, the block drives the inclusive upper limit address, the enable bit and the 8-bit attribute code picked by the region's index. These outputs go to the address-matching logic downstream.

Top module: `mpu_region_regbank`

## Requirements
- R1: A region's limit output is the stored limit field (written from data bits 31:5) with 0x1F appended as bits 4:0. A limit read returns the limit field in bits 31:5, 0 in bit 4, the attribute index in bits 3:1 and the enable in bit 0. Write data bit 4 is discarded.
- R2: A synchronous active-low reset clears every enable bit of both copies, and clears the select register and both attribute words to 0. Limit fields and attribute indices keep their values through reset.
- R3: The word offsets are measured from BASE_ADDR (default 0xE000_ED90). The select register is at 0x00 and the main limit register at 0x04. The aliases n = 1, 2, 3 are at 0x08, 0x0C and 0x10, and each targets region {select[high bits], n[1:0]}. The attribute words 0 and 1 are at 0x20 and 0x24.
- R4: In the main window, a secure access uses the secure copy and a non-secure access uses the non-secure copy. A write to one copy never changes the other.
- R5: In the window at BASE_ADDR + 0x2_0000, a secure access reaches the non-secure copy and raises no fault. A non-secure access there faults, reads 0 and writes nothing.
- R6: An unprivileged access to any decoded address faults, reads 0 and changes no register.
- R7: A write whose byte strobes are not all 4'hF faults and changes nothing. Reads ignore the strobes.
- R8: Attribute word 0 holds index 0 in bits 7:0 up to index 3 in bits 31:24, and word 1 holds indices 4 to 7 in the same way. A region's attribute output is byte `index` of {word1, word0} of its own copy.
- R9: An access to an address that is not decoded (including unaligned addresses) reads 0 and never faults, whatever its privilege or security state.
- R10: The select register keeps only its low log2(REGIONS) bits and reads 0 above them.
- R11: Read data and the fault flag appear on the cycle after the request and are 0 when there is no request. A write is visible at the outputs and to reads from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low warm reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_strb | input | 4 | Byte strobes for writes |
| bus_priv | input | 1 | Requester is privileged |
| bus_secure | input | 1 | Requester is in the secure state |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| rsp_fault | output | 1 | Bus fault, one cycle after the request |
| rgn_limit_o | output | 2*REGIONS*32 | Inclusive limit per region, slot (copy*REGIONS + region), copy 0 = non-secure |
| rgn_attr_o | output | 2*REGIONS*8 | Looked-up attribute code per region, same slot order |
| rgn_en_o | output | 2*REGIONS | Region enable per region, same slot order |

## Verification
The register write lands on the clock edge that ends the request cycle. The response registers load on that same edge. So read data, the fault flag and all per-region outputs are due exactly one cycle after a request. The bench drives each request on a falling edge and samples every result on the next falling edge, which lies half a cycle after the updating edge. Each write is followed by a separate read or port sample, so every expectation is checked at the first cycle it is due.

// File: rtl/mpu_rb_pkg.sv
package mpu_rb_pkg;

  localparam int LIM_W  = 27;
  localparam int AIDX_W = 3;
  localparam int ATTR_W = 8;

  typedef enum logic [2:0] {
    K_NONE,
    K_SEL,
    K_LIM,
    K_ATTR0,
    K_ATTR1
  } reg_kind_e;

  // Inclusive upper limit: stored field followed by five ones
  function automatic logic [31:0] eff_limit(input logic [LIM_W-1:0] fld);
    return {fld, 5'h1F};
  endfunction

  // Read image of a limit register; bit 4 always reads 0
  function automatic logic [31:0] pack_lim(input logic [LIM_W-1:0] fld,
                                           input logic [AIDX_W-1:0] idx,
                                           input logic en);
    return {fld, 1'b0, idx, en};
  endfunction

  // Alias target: low two bits of the select value replaced by n
  function automatic logic [7:0] alias_region(input logic [7:0] sel,
                                              input logic [1:0] n);
    return {sel[7:2], n};
  endfunction

  // Attribute byte chosen by index from the two concatenated words
  function automatic logic [ATTR_W-1:0] attr_pick(input logic [63:0] words,
                                                  input logic [AIDX_W-1:0] idx);
    return words[idx*8 +: 8];
  endfunction

endpackage

// File: rtl/mpu_rb_decode.sv
module mpu_rb_decode
  import mpu_rb_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'hE000_ED90,
  parameter logic [31:0] WIN_OFS   = 32'h0002_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid,
  input  logic [31:0] addr,
  input  logic        we,
  input  logic [3:0]  strb,
  input  logic        priv,
  input  logic        secure,
  output reg_kind_e   kind,
  output logic        alias_use,
  output logic [1:0]  alias_n,
  output logic        hit,
  output logic        in_win,
  output logic        bank_idx,
  output logic        fault,
  output logic        wr_ok,
  output logic        rd_ok
);

  localparam logic [31:0] SPAN = 32'h28;

  logic [31:0] off_main, off_win, off;
  logic        in_main;
  logic        refuse;

  assign off_main = addr - BASE_ADDR;
  assign off_win  = addr - BASE_ADDR - WIN_OFS;
  assign in_main  = off_main < SPAN;
  assign in_win   = off_win < SPAN;
  assign off      = in_win ? off_win : off_main;

  always_comb begin
    kind      = K_NONE;
    alias_use = 1'b0;
    alias_n   = 2'd0;
    if (in_main || in_win) begin
      unique case (off[5:0])
        6'h00: kind = K_SEL;
        6'h04: kind = K_LIM;
        6'h08: begin kind = K_LIM; alias_use = 1'b1; alias_n = 2'd1; end
        6'h0C: begin kind = K_LIM; alias_use = 1'b1; alias_n = 2'd2; end
        6'h10: begin kind = K_LIM; alias_use = 1'b1; alias_n = 2'd3; end
        6'h20: kind = K_ATTR0;
        6'h24: kind = K_ATTR1;
        default: kind = K_NONE;
      endcase
    end
  end

  assign hit      = kind != K_NONE;
  assign bank_idx = in_win ? 1'b0 : secure;
  assign refuse   = !priv || (in_win && !secure) || (we && !(&strb));
  assign fault    = valid && hit && refuse;
  assign wr_ok    = valid && hit && we && !refuse;
  assign rd_ok    = valid && hit && !we && !refuse;

  p_strobe_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && hit && we && !(&strb)) |-> (fault && !wr_ok));

  p_win_ns_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && in_win && hit && !secure) |-> (!wr_ok && !rd_ok));

endmodule

// File: rtl/mpu_rb_bank.sv
module mpu_rb_bank
  import mpu_rb_pkg::*;
#(
  parameter int REGIONS = 8,
  parameter int RW      = $clog2(REGIONS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  reg_kind_e             kind,
  input  logic                  alias_use,
  input  logic [1:0]            alias_n,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  output logic [REGIONS*32-1:0] lim_o,
  output logic [REGIONS*8-1:0]  attr_o,
  output logic [REGIONS-1:0]    en_o
);

  logic [RW-1:0]     sel_q;
  logic [LIM_W-1:0]  lim_q  [REGIONS];
  logic [AIDX_W-1:0] aidx_q [REGIONS];
  logic [REGIONS-1:0] en_q;
  logic [31:0]       aw0_q, aw1_q;
  logic [RW-1:0]     rgn;
  logic              wr_sel, wr_lim, wr_aw0, wr_aw1;
  logic              unused_wbits;

  assign unused_wbits = ^{wdata[31:RW], wdata[4]};

  assign rgn    = alias_use ? RW'(alias_region(8'(sel_q), alias_n)) : sel_q;
  assign wr_sel = we && kind == K_SEL;
  assign wr_lim = we && kind == K_LIM;
  assign wr_aw0 = we && kind == K_ATTR0;
  assign wr_aw1 = we && kind == K_ATTR1;

  // Reset-cleared state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      en_q  <= '0;
      aw0_q <= '0;
      aw1_q <= '0;
    end else begin
      if (wr_sel) sel_q <= wdata[RW-1:0];
      if (wr_lim) en_q[rgn] <= wdata[0];
      if (wr_aw0) aw0_q <= wdata;
      if (wr_aw1) aw1_q <= wdata;
    end
  end

  // Fields left untouched by warm reset
  always_ff @(posedge clk) begin
    if (rst_n && wr_lim) begin
      lim_q[rgn]  <= wdata[31:5];
      aidx_q[rgn] <= wdata[3:1];
    end
  end

  always_comb begin
    unique case (kind)
      K_SEL:   rdata = {{(32-RW){1'b0}}, sel_q};
      K_LIM:   rdata = pack_lim(lim_q[rgn], aidx_q[rgn], en_q[rgn]);
      K_ATTR0: rdata = aw0_q;
      K_ATTR1: rdata = aw1_q;
      default: rdata = '0;
    endcase
  end

  for (genvar r = 0; r < REGIONS; r++) begin : gen_rgn
    assign lim_o[r*32 +: 32] = eff_limit(lim_q[r]);
    assign attr_o[r*8 +: 8]  = attr_pick({aw1_q, aw0_q}, aidx_q[r]);
    assign en_o[r]           = en_q[r];
  end

  p_en_clear_r2: assert property (@(posedge clk)
    !rst_n |=> (en_q == '0 && sel_q == '0));

  p_sel_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> (sel_q == $past(wdata[RW-1:0])));

  p_attr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_aw0 || wr_aw1) |=> ($stable(aw0_q) && $stable(aw1_q)));

endmodule

// File: rtl/mpu_region_regbank.sv
module mpu_region_regbank
  import mpu_rb_pkg::*;
#(
  parameter int          REGIONS   = 8,
  parameter logic [31:0] BASE_ADDR = 32'hE000_ED90,
  parameter logic [31:0] WIN_OFS   = 32'h0002_0000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_valid,
  input  logic [31:0]             bus_addr,
  input  logic [31:0]             bus_wdata,
  input  logic                    bus_we,
  input  logic [3:0]              bus_strb,
  input  logic                    bus_priv,
  input  logic                    bus_secure,
  output logic [31:0]             rsp_rdata,
  output logic                    rsp_fault,
  output logic [2*REGIONS*32-1:0] rgn_limit_o,
  output logic [2*REGIONS*8-1:0]  rgn_attr_o,
  output logic [2*REGIONS-1:0]    rgn_en_o
);

  localparam int RW    = $clog2(REGIONS);
  localparam int NBANK = 2;

  reg_kind_e   dec_kind;
  logic        dec_alias_use, dec_hit, dec_in_win, dec_bank;
  logic [1:0]  dec_alias_n;
  logic        dec_fault, dec_wr_ok, dec_rd_ok;
  logic [NBANK-1:0] bank_we;
  logic [31:0] bank_rdata [NBANK];
  logic [31:0] rd_mux;

  mpu_rb_decode #(.BASE_ADDR(BASE_ADDR), .WIN_OFS(WIN_OFS)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (bus_valid),
    .addr     (bus_addr),
    .we       (bus_we),
    .strb     (bus_strb),
    .priv     (bus_priv),
    .secure   (bus_secure),
    .kind     (dec_kind),
    .alias_use(dec_alias_use),
    .alias_n  (dec_alias_n),
    .hit      (dec_hit),
    .in_win   (dec_in_win),
    .bank_idx (dec_bank),
    .fault    (dec_fault),
    .wr_ok    (dec_wr_ok),
    .rd_ok    (dec_rd_ok)
  );

  for (genvar b = 0; b < NBANK; b++) begin : gen_bank
    assign bank_we[b] = dec_wr_ok && (dec_bank == 1'(b));
    mpu_rb_bank #(.REGIONS(REGIONS), .RW(RW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (bank_we[b]),
      .kind     (dec_kind),
      .alias_use(dec_alias_use),
      .alias_n  (dec_alias_n),
      .wdata    (bus_wdata),
      .rdata    (bank_rdata[b]),
      .lim_o    (rgn_limit_o[b*REGIONS*32 +: REGIONS*32]),
      .attr_o   (rgn_attr_o[b*REGIONS*8 +: REGIONS*8]),
      .en_o     (rgn_en_o[b*REGIONS +: REGIONS])
    );
  end

  assign rd_mux = dec_rd_ok ? bank_rdata[dec_bank] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_rdata <= rd_mux;
      rsp_fault <= dec_fault;
    end
  end

  p_bank_we_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));

  p_lim_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_wr_ok && dec_kind == K_LIM) |=> $stable(rgn_limit_o));

  p_unpriv_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && dec_hit && !bus_priv) |=> (rsp_fault && rsp_rdata == '0));

  p_win_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && dec_hit && dec_in_win && !bus_secure) |=> rsp_fault);

  p_quiet_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !dec_hit) |=> (rsp_rdata == '0 && !rsp_fault));

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> (rsp_rdata == '0 && !rsp_fault));

endmodule

// File: tb/mpu_region_regbank_test.sv
module mpu_region_regbank_test;

  localparam int          N    = 8;
  localparam logic [31:0] BASE = 32'hE000_ED90;
  localparam logic [31:0] WIN  = 32'h0002_0000;
  localparam logic [31:0] O_SEL = 32'h00, O_LIM = 32'h04, O_A1 = 32'h08,
                          O_A2 = 32'h0C, O_A3 = 32'h10, O_AW0 = 32'h20, O_AW1 = 32'h24;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              bus_valid = 1'b0, bus_we = 1'b0, bus_priv = 1'b1, bus_secure = 1'b1;
  logic [31:0]       bus_addr = '0, bus_wdata = '0;
  logic [3:0]        bus_strb = 4'hF;
  logic [31:0]       rsp_rdata;
  logic              rsp_fault;
  logic [2*N*32-1:0] rgn_limit_o;
  logic [2*N*8-1:0]  rgn_attr_o;
  logic [2*N-1:0]    rgn_en_o;

  mpu_region_regbank #(.REGIONS(N)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_strb(bus_strb),
    .bus_priv(bus_priv), .bus_secure(bus_secure), .rsp_rdata(rsp_rdata),
    .rsp_fault(rsp_fault), .rgn_limit_o(rgn_limit_o), .rgn_attr_o(rgn_attr_o),
    .rgn_en_o(rgn_en_o)
  );

  int errs = 0, checks = 0;
  logic [31:0] rd;
  logic        flt;

  function automatic logic [31:0] lim_of(input int b, input int r);
    return rgn_limit_o[(b*N+r)*32 +: 32];
  endfunction
  function automatic logic [7:0] attr_of(input int b, input int r);
    return rgn_attr_o[(b*N+r)*8 +: 8];
  endfunction
  function automatic logic [31:0] want_lim(input logic [31:0] w);
    return w | 32'h1F;
  endfunction
  function automatic logic [31:0] want_read(input logic [31:0] w);
    return w & 32'hFFFF_FFEF;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [31:0] a, input logic [31:0] d, input logic we,
                     input logic [3:0] st, input logic pv, input logic sc);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_wdata = d; bus_we = we;
    bus_strb = st; bus_priv = pv; bus_secure = sc;
    @(negedge clk);
    rd = rsp_rdata; flt = rsp_fault;
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic sc);
    acc(a, d, 1'b1, 4'hF, 1'b1, sc);
  endtask
  task automatic rdr(input logic [31:0] a, input logic sc);
    acc(a, 32'h0, 1'b0, 4'hF, 1'b1, sc);
  endtask

  task automatic t_reset;
    chk("R2 enables after reset", 32'(rgn_en_o), 32'h0);
    rdr(BASE + O_SEL, 1'b1);
    chk("R2 select after reset", rd, 32'h0);
    rdr(BASE + O_AW0, 1'b1);
    chk("R2 attr word after reset", rd, 32'h0);
    chk("R11 no fault on good read", 32'(flt), 32'h0);
  endtask

  task automatic t_limit;
    wr(BASE + O_SEL, 32'h2, 1'b1);
    wr(BASE + O_LIM, 32'h2000_1237, 1'b1);
    chk("R1 R11 limit output next cycle", lim_of(1, 2), want_lim(32'h2000_1237));
    chk("R1 enable output", 32'(rgn_en_o[N+2]), 32'h1);
    rdr(BASE + O_LIM, 1'b1);
    chk("R1 limit read layout", rd, want_read(32'h2000_1237));
    chk("R1 other region untouched", 32'(rgn_en_o[N+0]), 32'h0);
  endtask

  task automatic t_alias;
    wr(BASE + O_SEL, 32'h5, 1'b1);
    wr(BASE + O_A3, 32'h4000_0001, 1'b1);
    chk("R3 alias 3 from select 5 hits region 7", lim_of(1, 7), 32'h4000_001F);
    wr(BASE + O_SEL, 32'h0, 1'b1);
    wr(BASE + O_A3, 32'h4100_0001, 1'b1);
    chk("R3 alias 3 from select 0 hits region 3", lim_of(1, 3), 32'h4100_001F);
    wr(BASE + O_SEL, 32'h7, 1'b1);
    rdr(BASE + O_LIM, 1'b1);
    chk("R3 main read of aliased write", rd, 32'h4000_0001);
    rdr(BASE + O_SEL, 1'b1);
    chk("R3 alias writes leave select", rd, 32'h7);
    wr(BASE + O_A1, 32'h4200_0001, 1'b1);
    chk("R3 alias 1 from select 7 hits region 5", lim_of(1, 5), 32'h4200_001F);
  endtask

  task automatic t_bank;
    wr(BASE + O_SEL, 32'h2, 1'b0);
    wr(BASE + O_LIM, 32'h5000_0003, 1'b0);
    chk("R4 non-secure copy written", lim_of(0, 2), 32'h5000_001F);
    chk("R4 secure copy unchanged", lim_of(1, 2), want_lim(32'h2000_1237));
    rdr(BASE + O_SEL, 1'b1);
    chk("R4 secure select independent", rd, 32'h7);
  endtask

  task automatic t_window;
    wr(BASE + WIN + O_LIM, 32'h6000_0005, 1'b1);
    chk("R5 secure window write no fault", 32'(flt), 32'h0);
    chk("R5 window reaches non-secure copy", lim_of(0, 2), 32'h6000_001F);
    acc(BASE + WIN + O_LIM, 32'h0, 1'b0, 4'hF, 1'b1, 1'b0);
    chk("R5 non-secure window read faults", 32'(flt), 32'h1);
    chk("R5 non-secure window read data", rd, 32'h0);
    acc(BASE + WIN + O_LIM, 32'h7700_0001, 1'b1, 4'hF, 1'b1, 1'b0);
    chk("R5 non-secure window write faults", 32'(flt), 32'h1);
    chk("R5 non-secure window write ignored", lim_of(0, 2), 32'h6000_001F);
  endtask

  task automatic t_unpriv;
    wr(BASE + O_SEL, 32'h2, 1'b1);
    acc(BASE + O_LIM, 32'h9900_0000, 1'b1, 4'hF, 1'b0, 1'b1);
    chk("R6 unprivileged write faults", 32'(flt), 32'h1);
    chk("R6 unprivileged write ignored", lim_of(1, 2), want_lim(32'h2000_1237));
    acc(BASE + O_LIM, 32'h0, 1'b0, 4'hF, 1'b0, 1'b1);
    chk("R6 unprivileged read faults", 32'(flt), 32'h1);
    chk("R6 unprivileged read data", rd, 32'h0);
  endtask

  task automatic t_strobe;
    acc(BASE + O_LIM, 32'h8800_0000, 1'b1, 4'h7, 1'b1, 1'b1);
    chk("R7 partial write faults", 32'(flt), 32'h1);
    chk("R7 partial write ignored", lim_of(1, 2), want_lim(32'h2000_1237));
    chk("R7 partial write keeps enable", 32'(rgn_en_o[N+2]), 32'h1);
    acc(BASE + O_LIM, 32'h0, 1'b0, 4'h0, 1'b1, 1'b1);
    chk("R7 read ignores strobes fault", 32'(flt), 32'h0);
    chk("R7 read ignores strobes data", rd, want_read(32'h2000_1237));
  endtask

  task automatic t_attr;
    wr(BASE + O_AW0, 32'h4433_2211, 1'b1);
    wr(BASE + O_AW1, 32'h8877_6655, 1'b1);
    chk("R8 index 3 picks word0 top byte", 32'(attr_of(1, 2)), 32'h44);
    wr(BASE + O_SEL, 32'h4, 1'b1);
    wr(BASE + O_LIM, 32'h7000_000B, 1'b1);
    chk("R8 index 5 picks word1 byte 1", 32'(attr_of(1, 4)), 32'h66);
    chk("R8 non-secure words still zero", 32'(attr_of(0, 2)), 32'h0);
    wr(BASE + O_AW0, 32'hAABB_CCDD, 1'b0);
    chk("R8 non-secure index 2 lookup", 32'(attr_of(0, 2)), 32'hBB);
    chk("R8 secure lookup unaffected", 32'(attr_of(1, 2)), 32'h44);
  endtask

  task automatic t_undecoded;
    rdr(BASE + 32'h14, 1'b1);
    chk("R9 hole reads zero", rd, 32'h0);
    chk("R9 hole no fault", 32'(flt), 32'h0);
    acc(BASE - 32'h4, 32'h0, 1'b0, 4'hF, 1'b0, 1'b0);
    chk("R9 outside unprivileged no fault", 32'(flt), 32'h0);
    acc(BASE + O_LIM + 32'h1, 32'hFFFF_FFFF, 1'b1, 4'hF, 1'b1, 1'b1);
    chk("R9 unaligned no fault", 32'(flt), 32'h0);
    chk("R9 unaligned write ignored", lim_of(1, 4), 32'h7000_001F);
  endtask

  task automatic t_select;
    wr(BASE + O_SEL, 32'hFFFF_FFFF, 1'b1);
    rdr(BASE + O_SEL, 1'b1);
    chk("R10 select truncated", rd, 32'h7);
  endtask

  task automatic t_warm;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R2 warm reset clears enables", 32'(rgn_en_o), 32'h0);
    chk("R2 warm reset keeps limit", lim_of(1, 2), want_lim(32'h2000_1237));
    rdr(BASE + O_SEL, 1'b1);
    chk("R2 warm reset clears select", rd, 32'h0);
    wr(BASE + O_SEL, 32'h2, 1'b1);
    rdr(BASE + O_LIM, 1'b1);
    chk("R2 warm reset keeps index", rd, 32'h2000_1226);
    chk("R2 attr word cleared gives zero", 32'(attr_of(1, 2)), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_limit();
    t_alias();
    t_bank();
    t_window();
    t_unpriv();
    t_strobe();
    t_attr();
    t_undecoded();
    t_select();
    t_warm();
    @(negedge clk);
    chk("R11 idle response zero", rsp_rdata, 32'h0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule